// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block follows the singly linked list of extended capability headers kept in a 4 KB configuration-space RAM. It reaches that RAM through a synchronous read port and a write port. A find operation takes a 16-bit capability ID. It returns the byte offset of the first header whose ID matches, together with the offset of the header visited just before it. An append operation checks a proposed location for a new capability. If the chain is not empty, it walks to the last header and rewrites that header's next pointer so that it points at the new location. It then writes the new header there.

Each header is one 32-bit dword. The ID sits in bits [15:0], the version in bits [19:16] and the byte offset of the next header in bits [31:20]. A next value of 0 ends the chain. Every walk starts at offset 0x100. A single start pulse begins an operation. `busy` is high while the operation runs, and a one-cycle `done` pulse presents the result, which stays on the result outputs until the next operation finishes. If both start inputs are high in the same idle cycle, the find operation is taken.

Top module: `ext_cap_chain_walker`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `rd_en` and `wr_en` are 0, and `res_offset` and `res_prev` are 0.
- R2: A find reads the header at 0x100 first. If that header reads as all zeros, the chain is empty: `done` comes with `res_offset` = 0, `res_prev` = 0 and `err` = 0.
- R3: A find compares `find_id` with header bits [15:0] and, when it stops at a match, returns that header's offset in `res_offset` and the previously visited offset in `res_prev`. `res_prev` is 0 if the match is at 0x100.
- R4: A find that reaches a header with next field (bits [31:20]) equal to 0 and no match returns `res_offset` = 0 and `res_prev` = the offset of that last header, with `err` = 0.
- R5: A next pointer that is non-zero and lies outside 0x100..0xFF8 ends the operation with `err` = 1, `res_offset` = 0 and `res_prev` = 0. No read is ever issued outside that range.
- R6: A walk that visits 1024 headers without a match or a chain end stops with `err` = 1. This guards against looping chains.
- R7: Timing: the first read is issued in the cycle after the start edge. Each header visit costs two cycles: a read cycle and a compare cycle. A find over h headers raises `done` 1 + 2h cycles after the start edge. `busy` is high from the cycle after the start until `done`, and `done` lasts one cycle.
- R8: An append is rejected in one cycle with `err` = 1 and no write when the offset is not a multiple of 4, is below 0x100, the size is below 8, or offset + size exceeds 0x1000.
- R9: An append at offset 0x100 writes only the header dword {12'h000, `app_ver`, `app_id`} to 0x100, without reading the chain. `done` comes 2 cycles after the start, with `res_offset` = 0x100 and `res_prev` = 0.
- R10: An append elsewhere walks to the chain end while never matching any ID. It writes the last header back with bits [31:20] replaced by the new offset and bits [19:0] kept. It then writes {12'h000, `app_ver`, `app_id`} at the new offset. `done` comes 3 + 2h cycles after the start, with `res_offset` = new offset and `res_prev` = last header offset.
- R11: An append at an offset other than 0x100 when the header at 0x100 reads all zeros ends with `err` = 1 and no write.
- R12: Start inputs seen while `busy` is high are ignored. The running operation's result and its single `done` pulse are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_find | input | 1 | Begin a find |
| find_id | input | 16 | Capability ID to search for |
| start_append | input | 1 | Begin an append |
| app_id | input | 16 | ID of the new capability |
| app_ver | input | 4 | Version of the new capability |
| app_offset | input | 12 | Byte offset of the new capability |
| app_size | input | 13 | Size in bytes of the new capability |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation failed |
| res_offset | output | 12 | Match offset, or new offset after append |
| res_prev | output | 12 | Offset of the preceding header |
| rd_en | output | 1 | RAM read strobe |
| rd_addr | output | 12 | RAM read byte offset |
| rd_data | input | 32 | RAM read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | 12 | RAM write byte offset |
| wr_data | output | 32 | RAM write data |

## Verification
Every result arrives with `done`. For a find over h headers, `done` is due 1 + 2h edges after the start edge. A rejected append is due after 1 edge, a direct append at 0x100 after 2 edges, and a chained append after 3 + 2h edges. The bench drives its inputs on falling edges and counts falling-edge samples from the start until `done`, then compares that count exactly with the figure computed from the number of headers it expects the walk to visit. It then checks that `done` has fallen one cycle later. The RAM model counts writes, so rejected appends and busy-time starts are checked by the write count and by the RAM contents read back from the model.

// File: rtl/ecw_pkg.sv
package ecw_pkg;
  localparam int OFF_W  = 12;
  localparam int ID_W   = 16;
  localparam int VER_W  = 4;
  localparam int DW     = 32;
  localparam int SIZE_W = 13;
  localparam int NXT_LSB = ID_W + VER_W;
  localparam logic [OFF_W:0] SPACE_BYTES = 13'h1000;
  localparam int MIN_CAP_BYTES = 8;

  typedef logic [OFF_W-1:0] off_t;
  typedef logic [DW-1:0]    hdr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_CMP, ST_PATCH, ST_HDR
  } walk_st_e;

  function automatic logic [ID_W-1:0] hdr_id(input hdr_t h);
    return h[ID_W-1:0];
  endfunction

  function automatic off_t hdr_next(input hdr_t h);
    return h[DW-1:NXT_LSB];
  endfunction

  function automatic logic off_in_window(input off_t o, input off_t lo, input off_t hi);
    return (o >= lo) && (o <= hi);
  endfunction

  function automatic logic append_fits(input off_t o, input logic [SIZE_W-1:0] sz,
                                       input off_t lo);
    logic [OFF_W+1:0] end_b;
    end_b = {2'b00, o} + {1'b0, sz};
    return (o[1:0] == 2'b00) && (o >= lo) && (sz >= SIZE_W'(MIN_CAP_BYTES)) &&
           (end_b <= {1'b0, SPACE_BYTES});
  endfunction

  function automatic hdr_t build_hdr(input logic [ID_W-1:0] id, input logic [VER_W-1:0] v);
    return {off_t'(0), v, id};
  endfunction

  function automatic hdr_t relink(input hdr_t h, input off_t nxt);
    return {nxt, h[NXT_LSB-1:0]};
  endfunction
endpackage

// File: rtl/ecw_hdr_decode.sv
module ecw_hdr_decode
  import ecw_pkg::*;
#(
  parameter int BASE_OFF = 'h100,
  parameter int TOP_OFF  = 'hFF8
) (
  input  hdr_t            hdr,
  input  logic [ID_W-1:0] want_id,
  input  logic            never_hit,
  output logic            hit,
  output logic            tail,
  output off_t            nxt,
  output logic            nxt_bad
);
  localparam off_t LO = off_t'(BASE_OFF);
  localparam off_t HI = off_t'(TOP_OFF);

  always_comb begin
    nxt     = hdr_next(hdr);
    hit     = !never_hit && (hdr_id(hdr) == want_id);
    tail    = (nxt == '0);
    nxt_bad = !tail && !off_in_window(nxt, LO, HI);
  end
endmodule

// File: rtl/ecw_append_guard.sv
module ecw_append_guard
  import ecw_pkg::*;
#(
  parameter int BASE_OFF = 'h100
) (
  input  off_t              off,
  input  logic [SIZE_W-1:0] size,
  output logic              legal,
  output logic              at_base
);
  localparam off_t LO = off_t'(BASE_OFF);

  always_comb begin
    legal   = append_fits(off, size, LO);
    at_base = (off == LO);
  end
endmodule

// File: rtl/ecw_hop_ctr.sv
module ecw_hop_ctr #(
  parameter int MAX_HOPS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(MAX_HOPS + 1);
  localparam logic [CW-1:0] LAST_V = CW'(MAX_HOPS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_V);

  // R6: the count never runs past the hop budget
  assert_hops_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (cnt < LAST_V));
endmodule

// File: rtl/ext_cap_chain_walker.sv
module ext_cap_chain_walker
  import ecw_pkg::*;
#(
  parameter int BASE_OFF = 'h100,
  parameter int TOP_OFF  = 'hFF8,
  parameter int MAX_HOPS = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_find,
  input  logic [15:0] find_id,
  input  logic        start_append,
  input  logic [15:0] app_id,
  input  logic [3:0]  app_ver,
  input  logic [11:0] app_offset,
  input  logic [12:0] app_size,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [11:0] res_offset,
  output logic [11:0] res_prev,
  output logic        rd_en,
  output logic [11:0] rd_addr,
  input  logic [31:0] rd_data,
  output logic        wr_en,
  output logic [11:0] wr_addr,
  output logic [31:0] wr_data
);
  localparam off_t BASE = off_t'(BASE_OFF);

  walk_st_e        st;
  off_t            cur, prv, new_off;
  logic            first, app_mode;
  logic [ID_W-1:0] want;
  hdr_t            new_hdr, tail_hdr;
  logic            done_q, err_q;
  off_t            res_off_q, res_prv_q;

  // decoded events brought out as named wires
  logic hit, tail, nxt_bad, hop_last, app_legal, app_at_base;
  off_t nxt;
  logic empty_seen, walk_fail, walk_cont;

  ecw_hdr_decode #(.BASE_OFF(BASE_OFF), .TOP_OFF(TOP_OFF)) u_dec (
    .hdr(rd_data), .want_id(want), .never_hit(app_mode),
    .hit(hit), .tail(tail), .nxt(nxt), .nxt_bad(nxt_bad)
  );

  ecw_append_guard #(.BASE_OFF(BASE_OFF)) u_guard (
    .off(app_offset), .size(app_size), .legal(app_legal), .at_base(app_at_base)
  );

  logic idle_start;
  assign idle_start = (st == ST_IDLE) && (start_find || start_append);
  assign empty_seen = (st == ST_CMP) && first && (rd_data == '0);
  assign walk_fail  = (st == ST_CMP) && !empty_seen && !hit && !tail && (nxt_bad || hop_last);
  assign walk_cont  = (st == ST_CMP) && !empty_seen && !hit && !tail && !nxt_bad && !hop_last;

  ecw_hop_ctr #(.MAX_HOPS(MAX_HOPS)) u_hops (
    .clk(clk), .rst_n(rst_n), .clr(idle_start), .inc(walk_cont), .last(hop_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cur <= '0; prv <= '0; new_off <= '0;
      first <= 1'b0; app_mode <= 1'b0; want <= '0;
      new_hdr <= '0; tail_hdr <= '0;
      done_q <= 1'b0; err_q <= 1'b0; res_off_q <= '0; res_prv_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start_find) begin
            want <= find_id; app_mode <= 1'b0;
            cur <= BASE; prv <= '0; first <= 1'b1;
            st <= ST_READ;
          end else if (start_append) begin
            new_off <= app_offset;
            new_hdr <= build_hdr(app_id, app_ver);
            if (!app_legal) begin
              done_q <= 1'b1; err_q <= 1'b1; res_off_q <= '0; res_prv_q <= '0;
            end else if (app_at_base) begin
              prv <= '0; st <= ST_HDR;
            end else begin
              app_mode <= 1'b1; cur <= BASE; prv <= '0; first <= 1'b1;
              st <= ST_READ;
            end
          end
        end
        ST_READ: st <= ST_CMP;
        ST_CMP: begin
          if (empty_seen) begin
            done_q <= 1'b1; err_q <= app_mode;
            res_off_q <= '0; res_prv_q <= '0; st <= ST_IDLE;
          end else if (hit) begin
            done_q <= 1'b1; err_q <= 1'b0;
            res_off_q <= cur; res_prv_q <= prv; st <= ST_IDLE;
          end else if (tail) begin
            if (app_mode) begin
              tail_hdr <= rd_data; prv <= cur; st <= ST_PATCH;
            end else begin
              done_q <= 1'b1; err_q <= 1'b0;
              res_off_q <= '0; res_prv_q <= cur; st <= ST_IDLE;
            end
          end else if (walk_fail) begin
            done_q <= 1'b1; err_q <= 1'b1;
            res_off_q <= '0; res_prv_q <= '0; st <= ST_IDLE;
          end else begin
            prv <= cur; cur <= nxt; first <= 1'b0; st <= ST_READ;
          end
        end
        ST_PATCH: st <= ST_HDR;
        ST_HDR: begin
          done_q <= 1'b1; err_q <= 1'b0;
          res_off_q <= new_off; res_prv_q <= prv; st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_en   = (st == ST_READ);
    rd_addr = cur;
    wr_en   = (st == ST_PATCH) || (st == ST_HDR);
    wr_addr = (st == ST_PATCH) ? prv : new_off;
    wr_data = (st == ST_PATCH) ? relink(tail_hdr, new_off) : new_hdr;
  end

  assign busy       = (st != ST_IDLE);
  assign done       = done_q;
  assign err        = err_q;
  assign res_offset = res_off_q;
  assign res_prev   = res_prv_q;

  // R5: reads never leave the legal header window
  assert_rd_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr >= off_t'(BASE_OFF)) && (rd_addr <= off_t'(TOP_OFF)));
  // R5: a failed operation reports no offset
  assert_err_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (res_offset == '0));
  // R7: completion is a single-cycle pulse with busy already low
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);
  // R12: busy only ever rises after a start request
  assert_busy_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_find || start_append));
  // R10: a write is followed by a second write or by completion
  assert_write_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_en || done));
  // R10: read and write strobes never overlap
  assert_rw_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
endmodule

// File: tb/sim_ext_cap_chain_walker.sv
`timescale 1ns/1ps
module sim_ext_cap_chain_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_find = 1'b0, start_append = 1'b0;
  logic [15:0] find_id = '0, app_id = '0;
  logic [3:0]  app_ver = '0;
  logic [11:0] app_offset = '0;
  logic [12:0] app_size = '0;
  logic        busy, done, err, rd_en, wr_en;
  logic [11:0] res_offset, res_prev, rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;

  int checks = 0, fails = 0, wr_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ext_cap_chain_walker u0 (.*);

  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr[11:2]];
    if (wr_en) begin mem[wr_addr[11:2]] <= wr_data; wr_cnt <= wr_cnt + 1; end
  end

  // id, expected offset, expected previous, headers visited
  localparam logic [51:0] VEC [5] = '{
    {16'h0001, 12'h100, 12'h000, 12'd1},
    {16'h000B, 12'h140, 12'h100, 12'd2},
    {16'h0010, 12'h200, 12'h140, 12'd3},
    {16'h0003, 12'h3F0, 12'h200, 12'd4},
    {16'h0007, 12'h000, 12'h3F0, 12'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic load_chain();
    clear_mem();
    mem['h100 >> 2] = 32'h1401_0001;
    mem['h140 >> 2] = 32'h2002_000B;
    mem['h200 >> 2] = 32'h3F01_0010;
    mem['h3F0 >> 2] = 32'h0001_0003;
  endtask

  // runs one operation; returns falling-edge samples until done
  task automatic run_op(input bit is_find, output int lat);
    @(negedge clk);
    start_find = is_find; start_append = !is_find;
    @(negedge clk);
    start_find = 1'b0; start_append = 1'b0;
    lat = 1;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
  endtask

  task automatic after_done(input string req);
    @(negedge clk);
    chk({req, " done one cycle"}, done, 1'b0);
  endtask

  task automatic do_find(input logic [15:0] id, output int lat);
    find_id = id; run_op(1'b1, lat);
  endtask

  task automatic do_append(input logic [11:0] off, input logic [12:0] sz,
                           input logic [15:0] id, input logic [3:0] v, output int lat);
    app_offset = off; app_size = sz; app_id = id; app_ver = v; run_op(1'b0, lat);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat, w0;
    clear_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 err", err, 0);
    chk("R1 rd_en", rd_en, 0); chk("R1 wr_en", wr_en, 0);
    chk("R1 res_offset", res_offset, 0); chk("R1 res_prev", res_prev, 0);
    rst_n = 1'b1;

    // table of finds over a four-entry chain (R3, R4, R7)
    load_chain();
    for (int i = 0; i < 5; i++) begin
      do_find(VEC[i][51:36], lat);
      chk("R3 R4 offset", res_offset, VEC[i][35:24]);
      chk("R3 R4 prev", res_prev, VEC[i][23:12]);
      chk("R4 err", err, 0);
      chk("R7 latency", lat, 1 + 2 * VEC[i][11:0]);
      after_done("R7");
    end

    // R7 busy right after start
    find_id = 16'h0003;
    @(negedge clk); start_find = 1'b1;
    @(negedge clk); start_find = 1'b0;
    chk("R7 busy", busy, 1);
    while (!done) @(negedge clk);

    // R2 empty chain
    clear_mem();
    do_find(16'h0001, lat);
    chk("R2 offset", res_offset, 0); chk("R2 prev", res_prev, 0);
    chk("R2 err", err, 0); chk("R2 latency", lat, 3);

    // R8 rejected appends
    w0 = wr_cnt;
    do_append(12'h102, 13'd8, 16'h0005, 4'h1, lat);
    chk("R8 misaligned err", err, 1); chk("R8 latency", lat, 1);
    do_append(12'h0F0, 13'd8, 16'h0005, 4'h1, lat);
    chk("R8 low err", err, 1);
    do_append(12'h200, 13'd4, 16'h0005, 4'h1, lat);
    chk("R8 small err", err, 1);
    do_append(12'hFFC, 13'd8, 16'h0005, 4'h1, lat);
    chk("R8 overrun err", err, 1);
    do_append(12'hFF8, 13'd8, 16'h0005, 4'h1, lat);
    chk("R11 exact end but empty err", err, 1);
    @(negedge clk);
    chk("R8 R11 no write", wr_cnt, w0);

    // R11 append on empty chain away from base
    do_append(12'h200, 13'd16, 16'h0005, 4'h1, lat);
    chk("R11 err", err, 1); chk("R11 latency", lat, 3);
    @(negedge clk);
    chk("R11 no write", wr_cnt, w0);

    // R9 direct append at base
    do_append(12'h100, 13'd8, 16'h0001, 4'h1, lat);
    chk("R9 err", err, 0); chk("R9 latency", lat, 2);
    chk("R9 offset", res_offset, 12'h100); chk("R9 prev", res_prev, 0);
    @(negedge clk);
    chk("R9 header", mem['h100 >> 2], 32'h0001_0001);
    chk("R9 one write", wr_cnt, w0 + 1);

    // R10 chained append
    mem['h100 >> 2] = 32'h000A_0001;
    do_append(12'h140, 13'd12, 16'h000B, 4'h2, lat);
    chk("R10 err", err, 0); chk("R10 latency", lat, 5);
    chk("R10 offset", res_offset, 12'h140); chk("R10 prev", res_prev, 12'h100);
    @(negedge clk);
    chk("R10 patched tail", mem['h100 >> 2], 32'h140A_0001);
    chk("R10 new header", mem['h140 >> 2], 32'h0002_000B);
    do_append(12'h180, 13'd8, 16'h0001, 4'h3, lat);
    chk("R10 second latency", lat, 7);
    chk("R10 second prev", res_prev, 12'h140);
    @(negedge clk);
    chk("R10 second patch", mem['h140 >> 2], 32'h1802_000B);
    chk("R10 second header", mem['h180 >> 2], 32'h0003_0001);

    // R5 bad pointers
    load_chain();
    mem['h200 >> 2] = 32'h0C01_0010;
    do_find(16'h0007, lat);
    chk("R5 low err", err, 1); chk("R5 low offset", res_offset, 0);
    chk("R5 latency", lat, 7);
    mem['h200 >> 2] = 32'hFFC1_0010;
    do_find(16'h0007, lat);
    chk("R5 high err", err, 1); chk("R5 high prev", res_prev, 0);

    // R6 loop
    clear_mem();
    mem['h100 >> 2] = 32'h1001_0001;
    do_find(16'h0002, lat);
    chk("R6 err", err, 1); chk("R6 latency", lat, 2049);

    // R12 start while busy is ignored
    load_chain();
    w0 = wr_cnt;
    find_id = 16'h0010; app_offset = 12'h400; app_size = 13'd8;
    app_id = 16'h0009; app_ver = 4'h1;
    @(negedge clk); start_find = 1'b1;
    @(negedge clk); start_find = 1'b0; start_append = 1'b1; lat = 1;
    @(negedge clk); start_append = 1'b0; start_find = 1'b1; lat = 2;
    @(negedge clk); start_find = 1'b0; lat = 3;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk("R12 latency", lat, 7); chk("R12 offset", res_offset, 12'h200);
    chk("R12 err", err, 0);
    repeat (4) begin
      @(negedge clk);
      chk("R12 single done", done, 0);
    end
    chk("R12 no write", wr_cnt, w0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule